// File: doc/BRIEF.md
# Selectable Clock Post-Divider with Runt-Free Output Gating

This block takes a fast clock and produces a slower clock from it. A 2-bit code picks the divide ratio: 1, 2, 4 or 8. The code values are not in binary order. The output has a 50% duty cycle at every ratio. A true output and its complement are both provided.

An enable input turns the output on and off. Every change of the enable is retimed to the output clock, so it only takes effect while the output is low. A high phase is therefore never cut short, and a new high phase never starts part-way through.

For the divided ratios, the enable is registered at edges where the divided clock is in its low phase. When the ratio is 1, the input clock passes through a latch-based gate. That latch is transparent only while the input clock is low. Reset clears the counter and holds the output low. The output stays low until the enable is seen at a low point. The ratio code is expected to change only while the output is stopped.

Top module: `postdiv_gate`

## Requirements
- R1: Ratio code 00 divides by 2: while enabled, there is one output rising edge per 2 input rising edges, and each high phase lasts 1 input period.
- R2: Ratio code 01 divides by 4: there is one output rising edge per 4 input edges, and each high phase lasts 2 input periods.
- R3: Ratio code 10 divides by 8: there is one output rising edge per 8 input edges, and each high phase lasts 4 input periods.
- R4: Ratio code 11 passes the input clock through: one output rising edge per input rising edge, and each high phase lasts half an input period.
- R5: `clk_out_n` is always the inverse of `clk_out`.
- R6: While the enable is low (after the current high phase ends), `clk_out` stays low and `clk_out_n` stays high.
- R7: In the divided modes, the enable is taken only at output-low points. Every output high phase has exactly its full length, and no low phase is shorter than a high phase, whatever cycle the enable changes in.
- R8: In the pass-through mode, enable changes are captured only while the input clock is low. Each output high pulse is a full half input period, and toggling the enable during a low phase produces no pulse.
- R9: During reset, `clk_out` is low and `clk_out_n` is high. After reset, the output remains low while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Divide code: 00 gives ÷2, 01 gives ÷4, 10 gives ÷8, 11 gives ÷1 |
| out_en | input | 1 | Output enable, active high; retimed internally |
| clk_out | output | 1 | Divided clock output |
| clk_out_n | output | 1 | Complement of `clk_out` |

## Verification
The hardest case to reach is an enable change that lands in every possible phase of the divided clock. That includes the last cycle of a high phase and the cycle just before a rising edge, which are the cycles where a careless gate would emit a runt.

The stimulus sweeps the disable and re-enable points across every input-cycle offset inside an 8-cycle window, for each ratio. A pulse-width monitor timestamps every output edge and compares each phase against the half period that the ratio code implies. In the pass-through mode, the enable is also toggled inside input-low phases to show that the latch lets no pulse through.

// File: rtl/postdiv_gate.sv
module postdiv_gate #(
  parameter int CNT_W = 3
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [1:0]       ratio_sel,
  input  logic             out_en,
  output logic             clk_out,
  output logic             clk_out_n
);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             nx_bit;
  logic             bypass;
  logic             en_q;
  logic             div_q;
  logic             en_lat;

  assign bypass = (ratio_sel == 2'b11);
  assign cnt_nx = cnt + 1'b1;

  always_comb begin
    case (ratio_sel)
      2'b00:   nx_bit = cnt_nx[0];
      2'b01:   nx_bit = cnt_nx[1];
      2'b10:   nx_bit = cnt_nx[2];
      default: nx_bit = 1'b0;
    endcase
  end

  // enable is re-sampled only at edges that leave the divided clock low
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      en_q  <= 1'b0;
      div_q <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      div_q <= nx_bit & en_q;
      if (!nx_bit)
        en_q <= out_en & ~bypass;
    end
  end

  // pass-through gate: latch open only while the input clock is low
  always_latch begin
    if (!rst_n)
      en_lat = 1'b0;
    else if (!clk_in)
      en_lat = out_en & bypass;
  end

  assign clk_out   = bypass ? (clk_in & en_lat) : div_q;
  assign clk_out_n = ~clk_out;

  assert_compl_R5: assert property (@(negedge clk_in) disable iff (!rst_n)
    clk_out_n == ~clk_out);

  assert_gated_low_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    !en_q |-> !div_q);

  assert_en_at_low_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(en_q) |-> !div_q);

  assert_half_div2_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
    (ratio_sel == 2'b00 && div_q) |=> !div_q);

  assert_half_div4_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
    (ratio_sel == 2'b01 && $rose(div_q)) |=> div_q);

  assert_half_div8_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
    (ratio_sel == 2'b10 && $rose(div_q)) |=> div_q ##1 div_q ##1 div_q);

  assert_bypass_idle_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
    bypass |-> !div_q);

endmodule

// File: tb/test_postdiv_gate.sv
`timescale 1ns/1ps
module test_postdiv_gate;

  logic       clk_in = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic       out_en = 1'b1;
  logic       clk_out, clk_out_n;

  int    tests = 0, fails = 0;
  int    rises = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  longint t_rise = 0, t_fall = 0;

  postdiv_gate i_postdiv_gate (
    .clk_in(clk_in), .rst_n(rst_n), .ratio_sel(ratio_sel),
    .out_en(out_en), .clk_out(clk_out), .clk_out_n(clk_out_n)
  );

  always #10 clk_in = ~clk_in;

  function automatic int ratio_of(logic [1:0] c);
    case (c)
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 1;
    endcase
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk_in);
    #5;
  endtask

  // pulse-width monitor: R7 / R8 high phase exact, low phase no shorter
  always @(posedge clk_out) begin
    rises++;
    if (mon_on)
      check(($time - t_fall) >= ratio_of(ratio_sel) * 10, "R7/R8 low width",
            $time - t_fall, ratio_of(ratio_sel) * 10);
    t_rise = $time;
  end

  always @(negedge clk_out) begin
    if (mon_on)
      check(($time - t_rise) == ratio_of(ratio_sel) * 10, "R7/R8 high width",
            $time - t_rise, ratio_of(ratio_sel) * 10);
    t_fall = $time;
  end

  task automatic run_code(logic [1:0] code, string req);
    int d;
    d = ratio_of(code);
    out_en = 1'b0;
    cyc(16);
    ratio_sel = code;
    cyc(4);
    out_en = 1'b1;
    cyc(20);
    rises = 0;
    cyc(64);
    check(rises == 64 / d, req, rises, 64 / d);
    // R5 complement, sampled in both clock phases
    check(clk_out_n == ~clk_out, "R5", clk_out_n, ~clk_out);
    @(negedge clk_in); #5;
    check(clk_out_n == ~clk_out, "R5", clk_out_n, ~clk_out);
    cyc(1);
    // R7/R8 sweep of disable and re-enable points
    for (int off = 0; off < 8; off++) begin
      cyc(off + 1);
      out_en = 1'b0;
      cyc(12);
      check(clk_out == 1'b0, "R6 out low", clk_out, 0);
      check(clk_out_n == 1'b1, "R6 outn high", clk_out_n, 1);
      cyc(off);
      out_en = 1'b1;
      cyc(3);
    end
  endtask

  initial begin
    cyc(3);
    check(clk_out == 1'b0, "R9 reset low", clk_out, 0);
    check(clk_out_n == 1'b1, "R9 reset outn", clk_out_n, 1);
    out_en = 1'b0;
    @(negedge clk_in);
    rst_n = 1'b1;
    cyc(10);
    check(clk_out == 1'b0, "R9 stays low", clk_out, 0);
    check(rises == 0, "R9 no edge", rises, 0);
    mon_on = 1'b1;

    run_code(2'b00, "R1 rise count");
    run_code(2'b01, "R2 rise count");
    run_code(2'b10, "R3 rise count");
    run_code(2'b11, "R4 rise count");

    // R8: toggle enable while input clock is low, output must stay low
    out_en = 1'b0;
    cyc(4);
    rises = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_in); #3;
      out_en = 1'b1;
      #4;
      check(clk_out == 1'b0, "R8 no pulse in low", clk_out, 0);
      out_en = 1'b0;
    end
    cyc(2);
    check(rises == 0, "R8 no rise", rises, 0);
    out_en = 1'b1;
    cyc(2);
    check(clk_out == 1'b1, "R8 passes high", clk_out, 1);
    @(negedge clk_in); #5;
    check(clk_out == 1'b0, "R8 passes low", clk_out, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule